// File: doc/BRIEF.md
# Command Port and Windowed Status Front End

This block sits between a host register bridge and the datapath of a network controller. Every control action arrives as a 16-bit command word on one port. The block splits the word into an opcode and a parameter. It then does one of four things: it changes its own state (window selector, indication mask, event latches), or it fires a one-cycle strobe towards the transmit and receive datapath.

The host reads one combined status word. It carries three things: the events the datapath has raised, a flag showing that a command is still executing, and the number of the register window now selected. That window number also drives the register multiplexer outside this block. An event can only latch when the host has enabled it through the indication mask. A latched event stays set until the host clears it with an acknowledge command that names it in a bit mask.

Each command holds the busy flag for a fixed number of cycles. The reset-class opcodes hold it for longer. The block drops any command that arrives while it is busy.

Top module: `nic_cmd_front`

## Requirements
- R1: After reset the status word reads 0x0000, the window selector is 0, the indication mask is 0 and no strobe is active.
- R2: A command is taken when cmdValid is high and busy is low. Its opcode is cmdWord[15:11] and its parameter is cmdWord[10:0].
- R3: Status bit 12 is high for exactly CMD_BUSY cycles after a command is taken. For opcodes 0x00, 0x05 and 0x0B it is high for exactly RST_BUSY cycles instead. The first of those cycles is the one that follows the accepting edge.
- R4: A command that arrives while status bit 12 is high has no effect: no strobe fires, and neither the window, the mask nor the latches change.
- R5: Opcode 0x01 loads parameter bits 2:0 into the window selector. The selector is shown on winSel and in status bits 15:13 from the cycle after acceptance onward. Parameter bits 10:3 are ignored.
- R6: The following opcodes each raise their own strobe for exactly one cycle, in the cycle after acceptance: 0x04 receive enable, 0x03 receive disable, 0x05 receive reset, 0x09 transmit enable, 0x0A transmit disable, 0x0B transmit reset.
- R7: Event input bit i latches into status bit i when it pulses while mask bit i is set. The event bits are 0 to 2 and 4 to 10. Status bits 3 and 11 always read 0.
- R8: Opcode 0x0F replaces the indication mask with the parameter. An event whose mask bit is clear does not change the status word.
- R9: Opcode 0x0D clears every latched event whose bit is set in the parameter. Latched events whose bit is clear in the parameter are kept.
- R10: When an enabled event pulses in the same cycle that an acknowledge naming the same bit is taken, the event wins and the bit reads set afterwards.
- R11: Opcode 0x00 fires the global-reset strobe for one cycle and clears the window, the mask and all latched events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command word present this cycle |
| cmdWord | input | 16 | Opcode in 15:11, parameter in 10:0 |
| evtPulse | input | 11 | Event pulses from the datapath, one bit per status position |
| statusWord | output | 16 | Window, busy flag and latched events |
| winSel | output | 3 | Currently selected register window |
| globalRstStb | output | 1 | Global reset strobe |
| txEnStb | output | 1 | Transmit enable strobe |
| txDisStb | output | 1 | Transmit disable strobe |
| txRstStb | output | 1 | Transmit reset strobe |
| rxEnStb | output | 1 | Receive enable strobe |
| rxDisStb | output | 1 | Receive disable strobe |
| rxRstStb | output | 1 | Receive reset strobe |

## Verification
An acknowledge command and a datapath event can both target the same latch bit in the same clock edge. This collision is provoked by driving an acknowledge for a set of latched bits and, in the same cycle, an enabled event pulse on one of those bits. The result is judged by the status word read once the command has gone idle: the colliding bit must still be set, and the other acknowledged bits must be clear. A second overlap, a command presented while the block is still busy, is provoked by holding a window change during the busy period. It is judged by an unchanged window and by the absence of any strobe.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;
  localparam int CMD_W = 16;
  localparam int OPC_W = 5;
  localparam int PAR_W = 11;
  localparam int WIN_W = 3;
  localparam int EVT_W = 11;
  // event positions that exist; bit 3 is a hole
  localparam logic [EVT_W-1:0] EVT_VALID = 11'h7F7;

  localparam logic [OPC_W-1:0] OPC_GLOBAL_RST = 5'h00;
  localparam logic [OPC_W-1:0] OPC_SEL_WIN    = 5'h01;
  localparam logic [OPC_W-1:0] OPC_RX_DIS     = 5'h03;
  localparam logic [OPC_W-1:0] OPC_RX_EN      = 5'h04;
  localparam logic [OPC_W-1:0] OPC_RX_RST     = 5'h05;
  localparam logic [OPC_W-1:0] OPC_TX_EN      = 5'h09;
  localparam logic [OPC_W-1:0] OPC_TX_DIS     = 5'h0A;
  localparam logic [OPC_W-1:0] OPC_TX_RST     = 5'h0B;
  localparam logic [OPC_W-1:0] OPC_ACK        = 5'h0D;
  localparam logic [OPC_W-1:0] OPC_IND_EN     = 5'h0F;

  // control -> state datapath, valid in the accepting cycle
  typedef struct packed {
    logic             wipe;
    logic             loadWin;
    logic             loadMask;
    logic             ack;
    logic [PAR_W-1:0] param;
  } regStrobe_t;

  // control -> line strobes, registered
  typedef struct packed {
    logic globalRst;
    logic txEn;
    logic txDis;
    logic txRst;
    logic rxEn;
    logic rxDis;
    logic rxRst;
  } lineStrobe_t;
endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_cmd_pkg::*;
#(
  parameter int CMD_BUSY = 3,
  parameter int RST_BUSY = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [CMD_W-1:0]   cmdWord,
  output logic               busy,
  output regStrobe_t         regStb,
  output lineStrobe_t        lineStb
);
  localparam int MAX_BUSY = (RST_BUSY > CMD_BUSY) ? RST_BUSY : CMD_BUSY;
  localparam int CNT_W    = $clog2(MAX_BUSY + 1);

  logic [CNT_W-1:0] busyCnt;
  logic [OPC_W-1:0] opc;
  logic [PAR_W-1:0] par;
  logic             accept;
  logic             isLong;
  lineStrobe_t      lineNext;

  assign opc    = cmdWord[CMD_W-1:PAR_W];
  assign par    = cmdWord[PAR_W-1:0];
  assign accept = cmdValid && !busy;
  assign busy   = (busyCnt != '0);
  assign isLong = (opc == OPC_GLOBAL_RST) || (opc == OPC_RX_RST) || (opc == OPC_TX_RST);

  always_ff @(posedge clk) begin
    if (!rstN)
      busyCnt <= '0;
    else if (accept)
      busyCnt <= isLong ? CNT_W'(RST_BUSY) : CNT_W'(CMD_BUSY);
    else if (busy)
      busyCnt <= busyCnt - 1'b1;
  end

  always_comb begin
    regStb          = '0;
    regStb.param    = par;
    regStb.wipe     = accept && (opc == OPC_GLOBAL_RST);
    regStb.loadWin  = accept && (opc == OPC_SEL_WIN);
    regStb.loadMask = accept && (opc == OPC_IND_EN);
    regStb.ack      = accept && (opc == OPC_ACK);
  end

  always_comb begin
    lineNext           = '0;
    lineNext.globalRst = accept && (opc == OPC_GLOBAL_RST);
    lineNext.txEn      = accept && (opc == OPC_TX_EN);
    lineNext.txDis     = accept && (opc == OPC_TX_DIS);
    lineNext.txRst     = accept && (opc == OPC_TX_RST);
    lineNext.rxEn      = accept && (opc == OPC_RX_EN);
    lineNext.rxDis     = accept && (opc == OPC_RX_DIS);
    lineNext.rxRst     = accept && (opc == OPC_RX_RST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) lineStb <= '0;
    else       lineStb <= lineNext;
  end

  // R3: a taken command shows busy in the following cycle
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);

  // R4: nothing taken while busy, so no strobe in the next cycle
  assert_ignore_while_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (lineStb == '0));

  // R6: transmit enable strobe only follows a taken 0x09 word
  assert_txen_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineStb.txEn |-> ($past(cmdValid) && !$past(busy) && ($past(cmdWord[CMD_W-1:PAR_W]) == OPC_TX_EN)));
endmodule

// File: rtl/nic_evt_path.sv
module nic_evt_path
  import nic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       regStb,
  input  logic [EVT_W-1:0] evtPulse,
  output logic [WIN_W-1:0] winQ,
  output logic [EVT_W-1:0] latchQ
);
  logic [EVT_W-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN || regStb.wipe)
      winQ <= '0;
    else if (regStb.loadWin)
      winQ <= regStb.param[WIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || regStb.wipe)
      maskQ <= '0;
    else if (regStb.loadMask)
      maskQ <= regStb.param[EVT_W-1:0] & EVT_VALID;
  end

  for (genvar i = 0; i < EVT_W; i++) begin : gEvt
    if (EVT_VALID[i]) begin : gLive
      logic clrBit;
      assign clrBit = regStb.ack && regStb.param[i];
      always_ff @(posedge clk) begin
        if (!rstN || regStb.wipe)
          latchQ[i] <= 1'b0;
        else
          latchQ[i] <= (latchQ[i] && !clrBit) || (evtPulse[i] && maskQ[i]);
      end
    end else begin : gHole
      assign latchQ[i] = 1'b0;
    end
  end

  // R8: a bit can only newly set if its mask bit was set
  assert_masked_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchQ & ~$past(latchQ) & ~$past(maskQ)) == '0));

  // R5: window only moves on select or global reset
  assert_window_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(regStb.loadWin || regStb.wipe) |=> $stable(winQ));

  // R9: acknowledged bits without a fresh event are clear afterwards
  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    regStb.ack |=> ((latchQ & $past(regStb.param & ~evtPulse)) == '0));

  // R10: an enabled event always ends up latched, ack or not
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regStb.wipe |=> ((latchQ & $past(evtPulse & maskQ)) == $past(evtPulse & maskQ)));
endmodule

// File: rtl/nic_cmd_front.sv
module nic_cmd_front
  import nic_cmd_pkg::*;
#(
  parameter int CMD_BUSY = 3,
  parameter int RST_BUSY = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [15:0] cmdWord,
  input  logic [10:0] evtPulse,
  output logic [15:0] statusWord,
  output logic [2:0]  winSel,
  output logic        globalRstStb,
  output logic        txEnStb,
  output logic        txDisStb,
  output logic        txRstStb,
  output logic        rxEnStb,
  output logic        rxDisStb,
  output logic        rxRstStb
);
  logic             busy;
  regStrobe_t       regStb;
  lineStrobe_t      lineStb;
  logic [WIN_W-1:0] winQ;
  logic [EVT_W-1:0] latchQ;

  nic_cmd_ctrl #(.CMD_BUSY(CMD_BUSY), .RST_BUSY(RST_BUSY)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .busy(busy), .regStb(regStb), .lineStb(lineStb)
  );

  nic_evt_path uPath (
    .clk(clk), .rstN(rstN), .regStb(regStb), .evtPulse(evtPulse),
    .winQ(winQ), .latchQ(latchQ)
  );

  assign statusWord   = {winQ, busy, 1'b0, latchQ};
  assign winSel       = winQ;
  assign globalRstStb = lineStb.globalRst;
  assign txEnStb      = lineStb.txEn;
  assign txDisStb     = lineStb.txDis;
  assign txRstStb     = lineStb.txRst;
  assign rxEnStb      = lineStb.rxEn;
  assign rxDisStb     = lineStb.rxDis;
  assign rxRstStb     = lineStb.rxRst;
endmodule

// File: tb/tb_nic_cmd_front.sv
`timescale 1ns/1ps
module tb_nic_cmd_front;
  localparam int CB = 3;
  localparam int RB = 8;
  localparam logic [10:0] VALIDEV = 11'h7F7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdWord = '0;
  logic [10:0] evtPulse = '0;
  logic [15:0] statusWord;
  logic [2:0] winSel;
  logic globalRstStb, txEnStb, txDisStb, txRstStb, rxEnStb, rxDisStb, rxRstStb;

  int total = 0;
  int bad = 0;
  logic [2:0] expWin = '0;
  logic [10:0] expMask = '0;
  logic [10:0] expLatch = '0;

  nic_cmd_front #(.CMD_BUSY(CB), .RST_BUSY(RB)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .evtPulse(evtPulse), .statusWord(statusWord), .winSel(winSel),
    .globalRstStb(globalRstStb), .txEnStb(txEnStb), .txDisStb(txDisStb),
    .txRstStb(txRstStb), .rxEnStb(rxEnStb), .rxDisStb(rxDisStb), .rxRstStb(rxRstStb)
  );

  always #2.5 clk = ~clk;

  function automatic logic [6:0] stbVec();
    return {globalRstStb, txEnStb, txDisStb, txRstStb, rxEnStb, rxDisStb, rxRstStb};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns at the falling edge just after the accepting edge
  task automatic send(input logic [4:0] op, input logic [10:0] par);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = {op, par};
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (statusWord[12]) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle();
    int n;
    busyLen(n);
  endtask

  task automatic pulse(input logic [10:0] ev);
    @(negedge clk);
    evtPulse = ev;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic chkStatus(input string tag);
    chk(tag, statusWord, {expWin, 1'b0, 1'b0, expLatch});
  endtask

  initial begin
    #(5.0 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [4:0] ops [6];
    logic [6:0] stbs [6];
    logic [10:0] masks [4];
    logic [10:0] evs [3];
    ops[0]=5'h03; stbs[0]=7'b0000010;
    ops[1]=5'h04; stbs[1]=7'b0000100;
    ops[2]=5'h05; stbs[2]=7'b0000001;
    ops[3]=5'h09; stbs[3]=7'b0100000;
    ops[4]=5'h0A; stbs[4]=7'b0010000;
    ops[5]=5'h0B; stbs[5]=7'b0001000;
    masks[0]=11'h014; masks[1]=11'h3A1; masks[2]=11'h000; masks[3]=11'h7FF;
    evs[0]=11'h7FF; evs[1]=11'h155; evs[2]=11'h2AA;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", statusWord, 16'h0000);
    chk("R1 winSel", winSel, 3'd0);
    chk("R1 strobes", stbVec(), 7'd0);
    pulse(11'h7FF);
    chk("R1 mask zero after reset", statusWord, 16'h0000);

    // R5/R2 window sweep with junk in upper parameter bits
    for (int w = 0; w < 8; w++) begin
      send(5'h01, {8'hA5, 3'(w)});
      chk("R6 no strobe on select", stbVec(), 7'd0);
      busyLen(n);
      chk("R3 short busy length", n, CB);
      expWin = 3'(w);
      chk("R5 winSel", winSel, expWin);
      chkStatus("R2 R5 status window");
    end

    // R6/R3 strobe sweep
    for (int k = 0; k < 6; k++) begin
      send(ops[k], 11'h000);
      chk("R6 strobe pattern", stbVec(), stbs[k]);
      chk("R3 busy bit set", statusWord[12], 1'b1);
      @(negedge clk);
      chk("R6 strobe one cycle", stbVec(), 7'd0);
      busyLen(n);
      chk("R3 busy length", n + 1, (ops[k] == 5'h05 || ops[k] == 5'h0B) ? RB : CB);
    end

    // R4 command while busy ignored
    send(5'h09, 11'h000);
    cmdValid = 1'b1;
    cmdWord  = {5'h01, 11'h002};
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R4 no strobe while busy", stbVec(), 7'd0);
    idle();
    chk("R4 window unchanged", winSel, expWin);

    // R7 single-bit sweep with all events enabled
    send(5'h0F, 11'h7FF);
    idle();
    expMask = 11'h7FF & VALIDEV;
    for (int i = 0; i < 11; i++) begin
      pulse(11'(1 << i));
      expLatch = expLatch | (11'(1 << i) & expMask);
      chkStatus("R7 event latch bit");
    end
    send(5'h0D, 11'h7FF);
    idle();
    expLatch = '0;
    chkStatus("R9 ack all");

    // R8 mask patterns against event patterns
    for (int m = 0; m < 4; m++) begin
      send(5'h0F, masks[m]);
      idle();
      expMask = masks[m] & VALIDEV;
      for (int e = 0; e < 3; e++) begin
        send(5'h0D, 11'h7FF);
        idle();
        pulse(evs[e]);
        expLatch = evs[e] & expMask;
        chkStatus("R8 masked events");
      end
    end

    // R9 partial acknowledge
    pulse(11'h7FF);
    expLatch = 11'h7F7;
    chkStatus("R7 all events set");
    send(5'h0D, 11'h661);
    idle();
    expLatch = 11'h7F7 & ~11'h661;
    chkStatus("R9 partial ack");

    // R10 ack and event on the same bit in the same cycle
    @(negedge clk);
    cmdValid = 1'b1;
    cmdWord  = {5'h0D, 11'h196};
    evtPulse = 11'h004;
    @(negedge clk);
    cmdValid = 1'b0;
    evtPulse = '0;
    idle();
    expLatch = (expLatch & ~11'h196) | 11'h004;
    chkStatus("R10 event wins over ack");

    // R11 global reset
    send(5'h01, 11'h006);
    idle();
    expWin = 3'd6;
    pulse(11'h0F0);
    expLatch = expLatch | (11'h0F0 & expMask);
    chkStatus("R11 pre-reset state");
    send(5'h00, 11'h000);
    chk("R11 global strobe", stbVec(), 7'b1000000);
    busyLen(n);
    chk("R3 global busy length", n, RB);
    expWin = '0;
    expLatch = '0;
    expMask = '0;
    chkStatus("R11 cleared");
    pulse(11'h7FF);
    chkStatus("R11 mask cleared");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule